// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block watches over software by counting ticks of a slow source-clock enable pulse in an 8-bit up counter. Software must write a clear code to a code register often enough to keep the counter from wrapping past its top value. When the counter wraps, the block raises either a reset request or an interrupt request, chosen by a bit in the control register. A selectable clear window can restrict when a clear is accepted. With the window in force, a clear that arrives too early does not touch the counter; it raises an interrupt request instead.

The watchdog runs from reset. Stopping it takes two deliberate steps. First, software clears the enable bit. Second, it writes a disable key to the code register. The disable key beats an overflow that lands in the same cycle. Setting the enable bit again restarts counting from zero, and no key is needed for that. The live count is always visible on an output port.

Top module: `wdt_window_top`

## Requirements
- R1: After synchronous reset, the control register reads as enable=1, window=00 and action=1, so the value is 0x9. Control fields: bit 0 enable, bits 2:1 window select, bit 3 overflow action (1 = reset request, 0 = interrupt request). The counter is 0 and running, and both request outputs are low.
- R2: While running, the counter rises by one on each cycle with `tick` high and holds on cycles without `tick`, provided no write takes effect.
- R3: When `tick` arrives at count 0xFF, the counter wraps to 0 and one single-cycle pulse appears on `rst_req_o` if action=1, or on `irq_req_o` if action=0. The pulse appears in the cycle after the wrapping edge, and the two requests never pulse together.
- R4: Writing 0xB1 to the code register (`wr_sel`=1) while the enable bit is 0 stops the counter and forces it to 0, with no request. While stopped, ticks leave it at 0. The same write while the enable bit is 1 has no effect.
- R5: If a valid 0xB1 disable write and an overflow fall in the same cycle, the disable wins and no request pulse is produced.
- R6: Writing the control register (`wr_sel`=0) with bit 0 set while stopped restarts counting from 0. No code write is needed.
- R7: With window 00, a write of clear code 0x4E sets the counter to 0 at any count value.
- R8: With a non-zero window, a 0x4E clear is accepted only when the count is at least 0x80 (window 01), 0xC0 (window 10) or 0xE0 (window 11). An accepted clear sets the count to 0 and raises no request.
- R9: A 0x4E clear outside the allowed range gives a one-cycle `irq_req_o` pulse. The counter is not cleared and still advances on `tick` that cycle.
- R10: A code-register write of any value other than 0x4E or 0xB1 has no effect on the count or the requests.
- R11: A 0x4E clear while the watchdog is stopped has no effect and raises no request.
- R12: An accepted clear in the same cycle as an overflow tick leaves the count at 0 and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Source-clock enable pulse, one system cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control register, 1 code register |
| wr_data | input | 8 | Write data |
| cnt_o | output | 8 | Live counter value |
| rst_req_o | output | 1 | One-cycle reset request on overflow |
| irq_req_o | output | 1 | One-cycle interrupt request (overflow or early clear) |

## Verification
Directed sequences walk the counter to each window threshold and to one count below it. They separate accepted clears from early clears, and check that an early clear neither zeros the count nor stalls it. Same-cycle collisions are forced at count 0xFF: disable with overflow, and clear with overflow. These show that the priority order is applied, not just the individual functions. Seeded random traffic then mixes dense ticks with sparse writes of keys, stray codes and control values. This covers overflow under both actions, restarts after disable, and window changes in mid-count. Every cycle is compared against a reference model built from the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] CODE_CLEAR   = 8'h4E;
  localparam logic [DATA_W-1:0] CODE_DISABLE = 8'hB1;

  typedef struct packed {
    logic       act;   // 1: reset request on overflow, 0: interrupt request
    logic [1:0] win;   // clear window select
    logic       en;    // enable bit
  } wdt_ctrl_t;

  localparam int CTRL_W = $bits(wdt_ctrl_t);
  localparam wdt_ctrl_t CTRL_RST = '{act: 1'b1, win: 2'b00, en: 1'b1};
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output wdt_ctrl_t         ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= CTRL_RST;
    else if (we) ctrl_q <= wdt_ctrl_t'(wdata);
  end
endmodule

// File: rtl/wdt_win_chk.sv
module wdt_win_chk #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       win,
  output logic             ok
);
  localparam int N_WIN = 4;
  logic [N_WIN-1:0] top_ones;

  assign top_ones[0] = 1'b1;
  // window s accepts a clear when the s leading count bits are all one
  for (genvar s = 1; s < N_WIN; s++) begin : g_win
    assign top_ones[s] = &cnt[CNT_W-1 -: s];
  end

  assign ok = top_ones[win];
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             dis_cmd,
  input  logic             clr_cmd,
  input  logic             clr_ok,
  input  logic             act,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             rst_req_q,
  output logic             irq_req_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrap;
  assign wrap = tick && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      run_q     <= 1'b1;
      rst_req_q <= 1'b0;
      irq_req_q <= 1'b0;
    end else begin
      rst_req_q <= 1'b0;
      irq_req_q <= 1'b0;
      if (dis_cmd && run_q) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (start && !run_q) begin
        run_q <= 1'b1;
      end else if (run_q) begin
        if (clr_cmd && clr_ok) begin
          cnt_q <= '0;
        end else begin
          if (clr_cmd) irq_req_q <= 1'b1;
          if (tick)    cnt_q     <= cnt_q + 1'b1;
          if (wrap) begin
            if (act) rst_req_q <= 1'b1;
            else     irq_req_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              rst_req_o,
  output logic              irq_req_o
);
  wdt_ctrl_t ctrl;
  logic      ctrl_wr, code_wr, clr_cmd, dis_cmd, start, clr_ok, run_q;

  assign ctrl_wr = wr_en && !wr_sel;
  assign code_wr = wr_en &&  wr_sel;
  assign clr_cmd = code_wr && (wr_data == CODE_CLEAR);
  assign dis_cmd = code_wr && (wr_data == CODE_DISABLE) && !ctrl.en;
  assign start   = ctrl_wr && wr_data[0];

  wdt_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .we     (ctrl_wr),
    .wdata  (wr_data[CTRL_W-1:0]),
    .ctrl_q (ctrl)
  );

  wdt_win_chk #(.CNT_W(CNT_W)) u_win (
    .cnt (cnt_o),
    .win (ctrl.win),
    .ok  (clr_ok)
  );

  wdt_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .start     (start),
    .dis_cmd   (dis_cmd),
    .clr_cmd   (clr_cmd),
    .clr_ok    (clr_ok),
    .act       (ctrl.act),
    .cnt_q     (cnt_o),
    .run_q     (run_q),
    .rst_req_q (rst_req_o),
    .irq_req_q (irq_req_o)
  );
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              rst_req_o,
  input logic              irq_req_o,
  input logic              run,
  input logic              en,
  input logic [1:0]        win
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic dis_wr, clr_wr, go_wr;
  assign dis_wr = wr_en && wr_sel && (wr_data == CODE_DISABLE);
  assign clr_wr = wr_en && wr_sel && (wr_data == CODE_CLEAR);
  assign go_wr  = wr_en && !wr_sel && wr_data[0];

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst) !(rst_req_o && irq_req_o)); // R3
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) rst_req_o |=> !rst_req_o); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst) (!tick && !wr_en) |=> $stable(cnt_o)); // R2
  AST_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !wr_en && cnt_o != MAXV) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R2
  AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (run && dis_wr && !en) |=> (cnt_o == '0 && !run && !rst_req_o && !irq_req_o)); // R4
  AST_DISABLE_BEATS_OVF: assert property (@(posedge clk) disable iff (rst)
    (run && dis_wr && !en && tick && cnt_o == MAXV) |=> (!rst_req_o && !irq_req_o)); // R5
  AST_EARLY_CLEAR_IRQ: assert property (@(posedge clk) disable iff (rst)
    (run && clr_wr && win != 2'b00 && !cnt_o[CNT_W-1]) |=> irq_req_o); // R9
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!run && !go_wr) |=> (cnt_o == '0 && !rst_req_o && !irq_req_o)); // R11
endmodule

bind wdt_window_top wdt_window_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .cnt_o     (cnt_o),
  .rst_req_o (rst_req_o),
  .irq_req_o (irq_req_o),
  .run       (run_q),
  .en        (ctrl.en),
  .win       (ctrl.win)
);

// File: tb/sim_wdt_window_top.sv
`timescale 1ns/1ps
module sim_wdt_window_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] cnt_o;
  logic       rst_req_o, irq_req_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference state
  logic [7:0] m_cnt;
  logic       m_run, m_en, m_act, e_rst, e_irq;
  logic [1:0] m_win;

  always #2.5 clk = ~clk;

  wdt_window_top u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cnt_o(cnt_o), .rst_req_o(rst_req_o), .irq_req_o(irq_req_o)
  );

  function automatic bit win_ok(input logic [1:0] w, input logic [7:0] c);
    case (w)
      2'd0:    return 1'b1;
      2'd1:    return c >= 8'h80;
      2'd2:    return c >= 8'hC0;
      default: return c >= 8'hE0;
    endcase
  endfunction

  task automatic model(input logic we, input logic sel, input logic [7:0] d, input logic tk);
    e_rst = 1'b0; e_irq = 1'b0;
    if (we && sel && d == 8'hB1 && !m_en && m_run) begin
      m_run = 1'b0; m_cnt = 8'h00;
    end else if (we && !sel && d[0] && !m_run) begin
      m_run = 1'b1;
    end else if (m_run) begin
      if (we && sel && d == 8'h4E && win_ok(m_win, m_cnt)) m_cnt = 8'h00;
      else begin
        if (we && sel && d == 8'h4E) e_irq = 1'b1;
        if (tk) begin
          if (m_cnt == 8'hFF) begin
            if (m_act) e_rst = 1'b1; else e_irq = 1'b1;
          end
          m_cnt = m_cnt + 8'h01;
        end
      end
    end
    if (we && !sel) begin m_en = d[0]; m_win = d[2:1]; m_act = d[3]; end
  endtask

  task automatic check(input string rq, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h (t=%0t)", rq, what, got, exp, $time);
    end
  endtask

  task automatic cyc(input logic we, input logic sel, input logic [7:0] d, input logic tk, input string rq);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; tick = tk;
    @(posedge clk);
    model(we, sel, d, tk);
    #1;
    check(rq, "count", cnt_o, m_cnt);
    check(rq, "rst_req", {7'd0, rst_req_o}, {7'd0, e_rst});
    check(rq, "irq_req", {7'd0, irq_req_o}, {7'd0, e_irq});
  endtask

  task automatic adv_to(input logic [7:0] target, input string rq);
    while (m_cnt != target) cyc(1'b0, 1'b0, 8'h00, 1'b1, rq);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    m_cnt = 8'h00; m_run = 1'b1; m_en = 1'b1; m_act = 1'b1; m_win = 2'b00;
    #0;
    // R1: reset state at the ports
    check("R1", "count", cnt_o, 8'h00);
    check("R1", "rst_req", {7'd0, rst_req_o}, 8'h00);
    check("R1", "irq_req", {7'd0, irq_req_o}, 8'h00);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R1");           // enabled from reset: counts to 1
    // R2: ticks and idle cycles
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 8'h00, 1'b1, "R2");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 8'h00, 1'b0, "R2");
    // R3: overflow with action=1 (default) then action=0
    adv_to(8'hFF, "R3");
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R3");
    check("R3", "rst pulse", {7'd0, rst_req_o}, 8'h01);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, "R3");
    check("R3", "rst pulse ends", {7'd0, rst_req_o}, 8'h00);
    cyc(1'b1, 1'b0, 8'h01, 1'b0, "R3");            // en=1 win=00 act=0
    adv_to(8'hFF, "R3");
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R3");
    check("R3", "irq pulse", {7'd0, irq_req_o}, 8'h01);
    // R7: window 00 clear at low count
    adv_to(8'h03, "R7");
    cyc(1'b1, 1'b1, 8'h4E, 1'b1, "R7");
    check("R7", "cleared", cnt_o, 8'h00);
    // R8: window 01 at 0x80, window 11 at 0xE0
    cyc(1'b1, 1'b0, 8'h03, 1'b0, "R8");
    adv_to(8'h80, "R8");
    cyc(1'b1, 1'b1, 8'h4E, 1'b0, "R8");
    check("R8", "win01 clear", cnt_o, 8'h00);
    cyc(1'b1, 1'b0, 8'h07, 1'b0, "R8");
    adv_to(8'hE0, "R8");
    cyc(1'b1, 1'b1, 8'h4E, 1'b1, "R8");
    check("R8", "win11 clear", cnt_o, 8'h00);
    // R9: window 10 one below threshold
    cyc(1'b1, 1'b0, 8'h05, 1'b0, "R9");
    adv_to(8'hBF, "R9");
    cyc(1'b1, 1'b1, 8'h4E, 1'b1, "R9");
    check("R9", "early irq", {7'd0, irq_req_o}, 8'h01);
    check("R9", "kept counting", cnt_o, 8'hC0);
    cyc(1'b1, 1'b1, 8'h4E, 1'b0, "R8");            // now inside window
    check("R8", "win10 clear", cnt_o, 8'h00);
    // R10: stray codes
    cyc(1'b1, 1'b0, 8'h01, 1'b1, "R10");
    cyc(1'b1, 1'b1, 8'h4F, 1'b1, "R10");
    cyc(1'b1, 1'b1, 8'h00, 1'b0, "R10");
    check("R10", "untouched", cnt_o, 8'h02);
    // R4: key with enable set, then proper two-step disable
    cyc(1'b1, 1'b1, 8'hB1, 1'b1, "R4");
    check("R4", "key ignored when enabled", cnt_o, 8'h03);
    cyc(1'b1, 1'b0, 8'h00, 1'b1, "R4");
    check("R4", "still counting after en=0", cnt_o, 8'h04);
    cyc(1'b1, 1'b1, 8'hB1, 1'b1, "R4");
    check("R4", "stopped at zero", cnt_o, 8'h00);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 8'h00, 1'b1, "R4");
    // R11: clear while stopped
    cyc(1'b1, 1'b1, 8'h4E, 1'b1, "R11");
    check("R11", "no irq", {7'd0, irq_req_o}, 8'h00);
    // R6: restart
    cyc(1'b1, 1'b0, 8'h09, 1'b1, "R6");
    check("R6", "restart at zero", cnt_o, 8'h00);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R6");
    check("R6", "counting again", cnt_o, 8'h01);
    // R5: disable collides with overflow
    cyc(1'b1, 1'b0, 8'h08, 1'b1, "R5");            // en=0 act=1
    adv_to(8'hFF, "R5");
    cyc(1'b1, 1'b1, 8'hB1, 1'b1, "R5");
    check("R5", "no reset req", {7'd0, rst_req_o}, 8'h00);
    check("R5", "count zero", cnt_o, 8'h00);
    // R12: clear collides with overflow
    cyc(1'b1, 1'b0, 8'h09, 1'b0, "R12");
    adv_to(8'hFF, "R12");
    cyc(1'b1, 1'b1, 8'h4E, 1'b1, "R12");
    check("R12", "no reset req", {7'd0, rst_req_o}, 8'h00);
    check("R12", "count zero", cnt_o, 8'h00);
    // random traffic: dense ticks, sparse writes
    for (int i = 0; i < 30000; i++) begin
      logic       we, sel, tk;
      logic [7:0] d;
      tk  = ($urandom % 4) != 0;
      we  = ($urandom % 48) == 0;
      sel = $urandom % 2;
      case ($urandom % 4)
        0:       d = 8'h4E;
        1:       d = 8'hB1;
        2:       d = 8'h01 | {4'h0, 4'($urandom)};
        default: d = 8'($urandom);
      endcase
      cyc(we, sel, d, tk, "R2 R3 R9 random");
    end
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    finish_run();
  end
endmodule